// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block holds the management registers of a 10/100 Ethernet PHY as a station manager sees them. A management controller, which handles the serial framing elsewhere, presents a 5-bit register index with a read or write strobe and 16-bit write data. The block answers reads with 16-bit data one clock later. It keeps the control, status, advertisement, interrupt-source and interrupt-mask registers. It also returns fixed identity, partner-ability and expansion values.

A `link_down` input stands in for the line state. Every change of this input updates the link and negotiation bits of the status register and raises link interrupt events. Autonegotiation completes at once when it is requested. The interrupt-source register clears when it is read. A reset, from the pin or from the control register, restores the defaults and then applies the current link state again, so the link events become pending once more. A level interrupt output combines the pending events with the mask. Any access to an index that the block does not serve, or a write to a read-only index, raises a one-cycle error flag.

Top module: `phy_mgmt_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads these values. Control (index 0) becomes 0x3000, advertisement (index 4) 0x01E1 and the mask (index 30) zero. Status (index 1) becomes 0x7809 with the link applied per R9: 0x782D when the link is up, 0x7809 when it is down. Interrupt source (index 29) becomes 0x00C0 when the link is up and 0x0010 when it is down. `rd_data` and `acc_err` become 0.
- R2: A write to index 0 with bit 15 set does not store the data. It performs the full R1 load using the current `link_down`. A write to index 0 with bit 15 clear stores `wr_data & 0x7980`.
- R3: A write to index 0 with bit 15 clear and bit 12 set also sets status bit 5 (negotiation done) in the same edge.
- R4: A write to index 4 stores `(wr_data & 0x2D7F) | 0x0080`.
- R5: Reads return 0x0007 at index 2, 0xC0D1 at index 3, 0x0F71 at index 5 and 0x0001 at index 6. Writes to indices 1, 2, 3, 5, 6 and 29 change no register.
- R6: A read of index 29 returns the pending interrupt bits in the low byte and clears them at the same edge. A link event in that same cycle sets its bits after the clear.
- R7: A write to index 30 stores `wr_data[7:0]`. A read of index 30 returns `{8'h00, mask}`.
- R8: `irq_o` is high exactly when (interrupt source AND mask) is nonzero. It reflects an access or link event from the clock after that event.
- R9: A change of `link_down`, sampled against its value at the previous edge, is a link event. Reset records the current value, so reset itself makes no event. The link going down clears status bits 2 and 5 and sets interrupt bit 4. The link coming up sets status bits 2 and 5 and sets interrupt bits 7 (energy) and 6 (negotiation done). Bits 5, 3, 2 and 1 (remote fault, partner acknowledge, parallel-detect fault, page received) are defined but never raised.
- R10: A read of an index outside {0..6, 29, 30} returns 0. The error flag `acc_err` goes high for exactly the one cycle after that read, and after any write to an index outside {0, 4, 30}.
- R11: `rd_data` is registered. It updates only at an edge where `rd_en` is high and `wr_en` is low, and holds its value otherwise. When both strobes are high, the access is a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_idx | input | 5 | Register index of the access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access; wins over rd_en |
| wr_data | input | 16 | Write data |
| link_down | input | 1 | Line state, high when the link is lost |
| rd_data | output | 16 | Read data, valid from the clock after the read |
| irq_o | output | 1 | Level interrupt, pending AND mask nonzero |
| acc_err | output | 1 | One-cycle pulse after an unserved access |

## Verification
The hardest cases to reach are collisions in a single edge: a read that clears the interrupt source while a link change sets new bits, and a control write that requests negotiation while the link state moves. The stimulus drives a `link_down` toggle in the same cycle as a read of index 29. It also issues a soft reset while the link is down, so the re-applied link event must show up in the source register afterwards. A behavioural model in the bench tracks every register through these sequences and is compared with the outputs on every clock.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

   // register indices; the station manager decodes these positions
   localparam logic [4:0] IDX_CTL     = 5'd0;
   localparam logic [4:0] IDX_STS     = 5'd1;
   localparam logic [4:0] IDX_ID_HI   = 5'd2;
   localparam logic [4:0] IDX_ID_LO   = 5'd3;
   localparam logic [4:0] IDX_ADV     = 5'd4;
   localparam logic [4:0] IDX_PARTNER = 5'd5;
   localparam logic [4:0] IDX_EXPAN   = 5'd6;
   localparam logic [4:0] IDX_ISRC    = 5'd29;
   localparam logic [4:0] IDX_IMASK   = 5'd30;

   localparam logic [15:0] CTL_RST   = 16'h3000;
   localparam logic [15:0] STS_RST   = 16'h7809;
   localparam logic [15:0] ADV_RST   = 16'h01E1;
   localparam logic [15:0] CTL_WMASK = 16'h7980;
   localparam logic [15:0] ADV_WMASK = 16'h2D7F;
   localparam logic [15:0] ADV_FORCE = 16'h0080;
   localparam logic [15:0] STS_LINKB = 16'h0024;

   localparam int CTL_SOFT_RST_BIT = 15;
   localparam int CTL_ANEG_BIT     = 12;
   localparam int STS_ANEG_DONE    = 5;

   localparam int EV_ENERGY    = 7;
   localparam int EV_ANEG_DONE = 6;
   localparam int EV_LINK_LOST = 4;

   typedef struct packed {
      logic ctl;
      logic sts;
      logic id_hi;
      logic id_lo;
      logic adv;
      logic partner;
      logic expan;
      logic isrc;
      logic imask;
   } reg_sel_t;

   function automatic logic [15:0] apply_link_status(input logic [15:0] st,
                                                     input logic down);
      return down ? (st & ~STS_LINKB) : (st | STS_LINKB);
   endfunction

   function automatic logic [7:0] link_event_bits(input logic down);
      logic [7:0] ev;
      ev = '0;
      if (down) begin
         ev[EV_LINK_LOST] = 1'b1;
      end else begin
         ev[EV_ENERGY]    = 1'b1;
         ev[EV_ANEG_DONE] = 1'b1;
      end
      return ev;
   endfunction

endpackage

// File: rtl/phy_reg_decode.sv
module phy_reg_decode
   import phy_mgmt_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0] idx,
   output reg_sel_t         sel,
   output logic             rd_hit,
   output logic             wr_hit
);
   always_comb begin
      sel         = '0;
      sel.ctl     = (idx == IDX_W'(IDX_CTL));
      sel.sts     = (idx == IDX_W'(IDX_STS));
      sel.id_hi   = (idx == IDX_W'(IDX_ID_HI));
      sel.id_lo   = (idx == IDX_W'(IDX_ID_LO));
      sel.adv     = (idx == IDX_W'(IDX_ADV));
      sel.partner = (idx == IDX_W'(IDX_PARTNER));
      sel.expan   = (idx == IDX_W'(IDX_EXPAN));
      sel.isrc    = (idx == IDX_W'(IDX_ISRC));
      sel.imask   = (idx == IDX_W'(IDX_IMASK));
   end

   assign rd_hit = |sel;
   assign wr_hit = sel.ctl | sel.adv | sel.imask;

   always_comb begin
      a_r10_sel_onehot : assert ($onehot0(sel));
   end
endmodule

// File: rtl/phy_link_watch.sv
module phy_link_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic link_down,
   output logic link_evt
);
   logic seen_q;

   always_ff @(posedge clk) begin
      seen_q <= link_down;
   end

   // reset also captures the line, so no event fires out of reset
   assign link_evt = rst_n & (link_down ^ seen_q);

   a_r9_evt_on_change : assert property (@(posedge clk) disable iff (!rst_n)
      link_evt |-> (link_down != $past(link_down)));
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl #(
   parameter int INT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [INT_W-1:0] load_src,
   input  logic             clr,
   input  logic [INT_W-1:0] set_bits,
   input  logic             mask_we,
   input  logic [INT_W-1:0] mask_wd,
   output logic [INT_W-1:0] src,
   output logic [INT_W-1:0] mask,
   output logic             irq
);
   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         mask <= '0;
         src  <= load_src;
      end else begin
         if (mask_we) begin
            mask <= mask_wd;
         end
         src <= (clr ? '0 : src) | set_bits;
      end
   end

   assign irq = |(src & mask);

   a_r6_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !load && set_bits == '0) |=> (src == '0 && !irq));

   a_r8_zero_mask_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we && !load && mask_wd == '0) |=> !irq);

   a_r6_events_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load) |=> ((src & $past(src)) == $past(src)));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
   import phy_mgmt_pkg::*;
#(
   parameter int          IDX_W        = 5,
   parameter int          DATA_W       = 16,
   parameter int          INT_W        = 8,
   parameter logic [15:0] ID_HI_VAL    = 16'h0007,
   parameter logic [15:0] ID_LO_VAL    = 16'hC0D1,
   parameter logic [15:0] PARTNER_VAL  = 16'h0F71,
   parameter logic [15:0] EXPAN_VAL    = 16'h0001,
   parameter bit          RD_REG       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              link_down,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_o,
   output logic              acc_err
);
   localparam int PAD_W = DATA_W - INT_W;

   if (IDX_W != 5) begin : g_bad_idx
      $error("phy_mgmt_regs: IDX_W must be 5");
   end
   if (DATA_W != 16) begin : g_bad_data
      $error("phy_mgmt_regs: DATA_W must be 16");
   end
   if (INT_W < 8 || INT_W > DATA_W) begin : g_bad_int
      $error("phy_mgmt_regs: INT_W out of range");
   end

   reg_sel_t          sel;
   logic              rd_hit, wr_hit;
   logic              link_evt;
   logic              rd_fire, wr_fire;
   logic              soft_rst, load;
   logic [DATA_W-1:0] ctl_q, sts_q, adv_q, sts_d;
   logic [INT_W-1:0]  isrc, imask;
   logic [INT_W-1:0]  ev_now, ev_set;
   logic [DATA_W-1:0] rd_val;

   phy_reg_decode #(.IDX_W(IDX_W)) u_dec (
      .idx    (reg_idx),
      .sel    (sel),
      .rd_hit (rd_hit),
      .wr_hit (wr_hit)
   );

   phy_link_watch u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_down (link_down),
      .link_evt  (link_evt)
   );

   assign wr_fire  = wr_en;
   assign rd_fire  = rd_en & ~wr_en;
   assign soft_rst = wr_fire & sel.ctl & wr_data[CTL_SOFT_RST_BIT];
   assign load     = soft_rst;

   assign ev_now = INT_W'(link_event_bits(link_down));
   assign ev_set = link_evt ? ev_now : '0;

   phy_irq_ctrl #(.INT_W(INT_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_src (ev_now),
      .clr      (rd_fire & sel.isrc),
      .set_bits (ev_set),
      .mask_we  (wr_fire & sel.imask),
      .mask_wd  (wr_data[INT_W-1:0]),
      .src      (isrc),
      .mask     (imask),
      .irq      (irq_o)
   );

   // next status: write effects first, then the link event on top
   always_comb begin
      sts_d = sts_q;
      if (wr_fire && sel.ctl && wr_data[CTL_ANEG_BIT]) begin
         sts_d[STS_ANEG_DONE] = 1'b1;
      end
      if (link_evt) begin
         sts_d = apply_link_status(sts_d, link_down);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         ctl_q <= CTL_RST;
         adv_q <= ADV_RST;
         sts_q <= apply_link_status(STS_RST, link_down);
      end else begin
         if (wr_fire && sel.ctl) begin
            ctl_q <= wr_data & CTL_WMASK;
         end
         if (wr_fire && sel.adv) begin
            adv_q <= (wr_data & ADV_WMASK) | ADV_FORCE;
         end
         sts_q <= sts_d;
      end
   end

   always_comb begin
      rd_val = '0;
      if (sel.ctl)     rd_val = ctl_q;
      if (sel.sts)     rd_val = sts_q;
      if (sel.id_hi)   rd_val = ID_HI_VAL;
      if (sel.id_lo)   rd_val = ID_LO_VAL;
      if (sel.adv)     rd_val = adv_q;
      if (sel.partner) rd_val = PARTNER_VAL;
      if (sel.expan)   rd_val = EXPAN_VAL;
      if (sel.isrc)    rd_val = {{PAD_W{1'b0}}, isrc};
      if (sel.imask)   rd_val = {{PAD_W{1'b0}}, imask};
   end

   if (RD_REG) begin : g_rd_flop
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_q <= '0;
         end else if (rd_fire) begin
            rd_q <= rd_val;
         end
      end
      assign rd_data = rd_q;
   end else begin : g_rd_comb
      assign rd_data = rd_fire ? rd_val : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_err <= 1'b0;
      end else begin
         acc_err <= (wr_fire & ~wr_hit) | (rd_fire & ~rd_hit);
      end
   end

   a_r2_soft_reset : assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctl_q == CTL_RST && adv_q == ADV_RST && imask == '0));

   a_r3_aneg_done : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && sel.ctl && !wr_data[CTL_SOFT_RST_BIT] && wr_data[CTL_ANEG_BIT]
       && !(link_evt && link_down)) |=> sts_q[STS_ANEG_DONE]);

   a_r4_adv_fixed : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && sel.adv) |=> ((adv_q & ~ADV_WMASK) == ADV_FORCE));

   a_r9_link_lost : assert property (@(posedge clk) disable iff (!rst_n)
      (link_evt && link_down) |=>
         (!sts_q[2] && !sts_q[5] && isrc[EV_LINK_LOST]));

   a_r9_link_up : assert property (@(posedge clk) disable iff (!rst_n)
      (link_evt && !link_down) |=>
         (sts_q[2] && sts_q[5] && isrc[EV_ENERGY] && isrc[EV_ANEG_DONE]));

   a_r10_err_needs_access : assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> $past(rd_en || wr_en));

   a_r5_ro_untouched : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && (sel.sts || sel.id_hi || sel.id_lo || sel.partner
                   || sel.expan || sel.isrc)) |=> ($stable(ctl_q) && $stable(adv_q)));
endmodule

// File: tb/phy_mgmt_regs_tb_top.sv
module phy_mgmt_regs_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_idx = '0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        link_down = 1'b0;
   logic [15:0] rd_data;
   logic        irq_o;
   logic        acc_err;

   int checks = 0;
   int fails  = 0;
   bit started = 1'b0;

   always #5 clk = ~clk;

   phy_mgmt_regs dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_idx   (reg_idx),
      .rd_en     (rd_en),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .link_down (link_down),
      .rd_data   (rd_data),
      .irq_o     (irq_o),
      .acc_err   (acc_err)
   );

   // behavioural reference model
   logic [15:0] m_ctl, m_sts, m_adv, m_rd;
   logic [7:0]  m_src, m_msk;
   logic        m_err, m_lq;

   function automatic bit m_known(input logic [4:0] i);
      return (i <= 5'd6) || (i == 5'd29) || (i == 5'd30);
   endfunction

   function automatic logic [15:0] m_read(input logic [4:0] i);
      case (i)
         5'd0:  return m_ctl;
         5'd1:  return m_sts;
         5'd2:  return 16'h0007;
         5'd3:  return 16'hC0D1;
         5'd4:  return m_adv;
         5'd5:  return 16'h0F71;
         5'd6:  return 16'h0001;
         5'd29: return {8'h00, m_src};
         5'd30: return {8'h00, m_msk};
         default: return 16'h0000;
      endcase
   endfunction

   task automatic m_reset_load(input logic down);
      m_ctl = 16'h3000;
      m_adv = 16'h01E1;
      m_msk = 8'h00;
      m_sts = down ? 16'h7809 : 16'h782D;
      m_src = down ? 8'h10 : 8'hC0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_reset_load(link_down);
         m_rd = 16'h0;
         m_err = 1'b0;
         m_lq = link_down;
      end else begin
         bit ev;
         ev = (link_down != m_lq);
         m_lq = link_down;
         m_err = 1'b0;
         if (wr_en) begin
            if (reg_idx == 5'd0) begin
               if (wr_data[15]) m_reset_load(link_down);
               else begin
                  m_ctl = wr_data & 16'h7980;
                  if (wr_data[12]) m_sts = m_sts | 16'h0020;
               end
            end else if (reg_idx == 5'd4) m_adv = (wr_data & 16'h2D7F) | 16'h0080;
            else if (reg_idx == 5'd30) m_msk = wr_data[7:0];
            else m_err = 1'b1;
         end else if (rd_en) begin
            m_rd = m_read(reg_idx);
            if (reg_idx == 5'd29) m_src = 8'h00;
            if (!m_known(reg_idx)) m_err = 1'b1;
         end
         if (ev) begin
            if (link_down) begin
               m_sts = m_sts & ~16'h0024;
               m_src = m_src | 8'h10;
            end else begin
               m_sts = m_sts | 16'h0024;
               m_src = m_src | 8'hC0;
            end
         end
      end
   end

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (started) begin
         checks++;
         if (rd_data !== m_rd) begin
            fails++;
            $display("FAIL R11 model rd_data got %h exp %h", rd_data, m_rd);
         end
         checks++;
         if (irq_o !== (|(m_src & m_msk))) begin
            fails++;
            $display("FAIL R8 model irq_o got %b exp %b", irq_o, |(m_src & m_msk));
         end
         checks++;
         if (acc_err !== m_err) begin
            fails++;
            $display("FAIL R10 model acc_err got %b exp %b", acc_err, m_err);
         end
      end
   end

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   // one access per call; called at a negedge, returns at the next one
   task automatic cyc(input bit rd, input bit wr, input logic [4:0] idx,
                      input logic [15:0] wd);
      rd_en = rd; wr_en = wr; reg_idx = idx; wr_data = wd;
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [4:0] idx, input logic [15:0] exp, input string tag);
      cyc(1'b1, 1'b0, idx, 16'h0);
      chk(tag, rd_data, exp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      started = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset rd_data", rd_data, 16'h0);
      chk("R1 reset irq", {15'h0, irq_o}, 16'h0);
      chk("R1 reset acc_err", {15'h0, acc_err}, 16'h0);
      rd_chk(5'd0, 16'h3000, "R1 control");
      rd_chk(5'd1, 16'h782D, "R1 status link up");
      rd_chk(5'd4, 16'h01E1, "R1 advert");
      rd_chk(5'd30, 16'h0000, "R1 mask");
      rd_chk(5'd2, 16'h0007, "R5 id hi");
      rd_chk(5'd3, 16'hC0D1, "R5 id lo");
      rd_chk(5'd5, 16'h0F71, "R5 partner");
      rd_chk(5'd6, 16'h0001, "R5 expansion");
      cyc(1'b0, 1'b1, 5'd2, 16'hFFFF);
      chk("R5 ro write flags error", {15'h0, acc_err}, 16'h1);
      rd_chk(5'd2, 16'h0007, "R5 id hi after write");
      rd_chk(5'd29, 16'h00C0, "R6 pending after reset");
      rd_chk(5'd29, 16'h0000, "R6 cleared by read");
      link_down = 1'b1;
      cyc(1'b0, 1'b0, 5'd0, 16'h0);
      rd_chk(5'd1, 16'h7809, "R9 status link down");
      rd_chk(5'd29, 16'h0010, "R9 link lost event");
      cyc(1'b0, 1'b1, 5'd0, 16'h1000);
      rd_chk(5'd0, 16'h1000, "R2 control stored");
      rd_chk(5'd1, 16'h7829, "R3 aneg done set");
      cyc(1'b0, 1'b1, 5'd0, 16'h7FFF);
      rd_chk(5'd0, 16'h7980, "R2 control masked");
      cyc(1'b0, 1'b1, 5'd4, 16'hFFFF);
      rd_chk(5'd4, 16'h2DFF, "R4 advert ones");
      cyc(1'b0, 1'b1, 5'd4, 16'h0000);
      rd_chk(5'd4, 16'h0080, "R4 advert forced bit");
      cyc(1'b0, 1'b1, 5'd30, 16'hFFFF);
      rd_chk(5'd30, 16'h00FF, "R7 mask low byte");
      chk("R8 no pending no irq", {15'h0, irq_o}, 16'h0);
      link_down = 1'b0;
      cyc(1'b0, 1'b0, 5'd0, 16'h0);
      chk("R8 irq on link up", {15'h0, irq_o}, 16'h1);
      rd_chk(5'd1, 16'h782D, "R9 status link up");
      rd_chk(5'd29, 16'h00C0, "R9 link up events");
      chk("R8 irq drops after clear", {15'h0, irq_o}, 16'h0);
      cyc(1'b0, 1'b1, 5'd30, 16'h0010);
      link_down = 1'b1;
      cyc(1'b0, 1'b0, 5'd0, 16'h0);
      chk("R8 irq masked event", {15'h0, irq_o}, 16'h1);
      cyc(1'b0, 1'b1, 5'd30, 16'h0000);
      chk("R8 irq mask removed", {15'h0, irq_o}, 16'h0);
      rd_chk(5'd29, 16'h0010, "R6 pending kept under mask");
      cyc(1'b0, 1'b1, 5'd30, 16'h00AA);
      cyc(1'b0, 1'b1, 5'd0, 16'h8000);
      rd_chk(5'd0, 16'h3000, "R2 soft reset control");
      rd_chk(5'd1, 16'h7809, "R2 soft reset status");
      rd_chk(5'd30, 16'h0000, "R2 soft reset mask");
      rd_chk(5'd29, 16'h0010, "R2 soft reset relinks");
      rd_chk(5'd17, 16'h0000, "R10 unknown read zero");
      chk("R10 error pulse", {15'h0, acc_err}, 16'h1);
      cyc(1'b0, 1'b0, 5'd0, 16'h0);
      chk("R10 error one cycle", {15'h0, acc_err}, 16'h0);
      chk("R11 rd holds when idle", rd_data, 16'h0000);
      cyc(1'b0, 1'b1, 5'd31, 16'h1234);
      chk("R10 unknown write error", {15'h0, acc_err}, 16'h1);
      cyc(1'b0, 1'b1, 5'd1, 16'hFFFF);
      chk("R5 status write error", {15'h0, acc_err}, 16'h1);
      rd_chk(5'd1, 16'h7809, "R5 status unchanged");
      rd_chk(5'd0, 16'h3000, "R11 read control");
      cyc(1'b1, 1'b1, 5'd4, 16'h0000);
      chk("R11 write wins rd holds", rd_data, 16'h3000);
      rd_chk(5'd4, 16'h0080, "R11 write took effect");
      link_down = 1'b0;
      rd_chk(5'd29, 16'h0000, "R6 read during event");
      rd_chk(5'd29, 16'h00C0, "R6 event survives clear");
      link_down = 1'b1;
      rst_n = 1'b0;
      cyc(1'b0, 1'b0, 5'd0, 16'h0);
      cyc(1'b0, 1'b0, 5'd0, 16'h0);
      rst_n = 1'b1;
      chk("R1 reset rd cleared", rd_data, 16'h0000);
      rd_chk(5'd29, 16'h0010, "R1 reset link down src");
      rd_chk(5'd1, 16'h7809, "R1 reset link down status");
      cyc(1'b0, 1'b0, 5'd0, 16'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule